// File: doc/BRIEF.md
# Two-Window Bit-Stream Capture Controller

This block records two short windows of a fast single-bit stream, such as the output of a one-bit modulator, so that software can cross-correlate them later and estimate the autocorrelation of the stream. The serial input is first grouped into 4-bit words, so all capture logic runs once every fourth bit clock. Two banks of 128 bits each are then filled one after the other. Between the last word of the first bank and the first word of the second, a programmable number of bit periods is dropped. A gap of zero gives one unbroken 256-bit window.

When both banks are full, the block shifts all 256 stored bits out on a serial pin. The output advances one bit for each readout strobe. The readout clock is a single-cycle enable, `rd_step`, sampled in the bit-clock domain.

The user sets the gap, pulses `arm`, and feeds bits. The user watches `busy`, steps the readout, and gets a one-cycle `done` after the last bit.

Top module: `seg_capture_ctrl`

## Requirements
- R1: The first captured bit is the one sampled on the clock edge after the edge that accepts `arm`. Within each group of four captured bits, the earliest goes to lane 0 and the latest to lane 3.
- R2: The first bank holds stream bits 0 to 127 (32 words of 4 lanes).
- R3: With a gap of G bit periods, G a multiple of 4, the second bank holds stream bits 128+G to 255+G. Gaps up to 16380 bit periods are supported.
- R4: With a gap of 0, the two banks together hold stream bits 0 to 255 without a break.
- R5: In readout, `sout` presents bit k of the readout order at position k, for k from 0 to 255. Positions 0 to 127 carry bank bits 0 to 127 in stream order. Positions 128 to 255 carry the second bank in stream order.
- R6: `sout` moves to the next position only on a cycle with `rd_step` high. It stays unchanged otherwise. A `rd_step` pulse before readout begins has no effect on the readout order.
- R7: `arm` has no effect while a capture or readout is in progress.
- R8: `busy` is high from the cycle after `arm` is accepted until the last readout step. It is low when the block is idle.
- R9: After the 256th `rd_step`, `done` is high for exactly one cycle with `busy` low. The block is then idle and can be armed again.
- R10: After synchronous reset, `busy`, `done` and `sout` are all 0. A reset during a capture abandons that capture.
- R11: The two low bits of `gap_bits` are discarded. A gap that is not a multiple of 4 acts as the next lower multiple of 4.
- R12: `gap_bits` is sampled only when `arm` is accepted. Changing it during a capture has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial stream, one bit per clock |
| arm | input | 1 | Start request, honoured only when idle |
| gap_bits | input | 14 | Bit periods to drop between the two banks |
| rd_step | input | 1 | Readout advance strobe |
| sout | output | 1 | Serial readout data |
| busy | output | 1 | Capture or readout in progress |
| done | output | 1 | One-cycle pulse after the last readout bit |

## Verification
Two events can land on the same clock edge: a stray `arm` or `rd_step` can arrive on the edge where a captured word is stored in a bank or dropped in the gap. The bench provokes this by pulsing `arm` and `rd_step` in the middle of the first bank, in the middle of the gap, and while the second bank fills. It also changes `gap_bits` right after arming. The bench judges the result by comparing all 256 readout bits with a stream computed independently in the bench. A restarted capture, a shifted gap, or an early readout step would each misplace every later bit.

// File: rtl/seg_capture_pkg.sv
// Shared types for the two-window capture controller.
// Assumes: nothing beyond IEEE 1800-2017.
package seg_capture_pkg;

    // Controller phases, in the order they are visited.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FILL_A  = 3'd1,
        ST_SKIP    = 3'd2,
        ST_FILL_B  = 3'd3,
        ST_READOUT = 3'd4,
        ST_DONE    = 3'd5
    } cap_state_t;

endpackage

// File: rtl/seg_capture_demux.sv
// Serial-to-parallel front end: groups LANES consecutive bits into one word.
// The earliest bit of a group lands in lane 0. 'sync' restarts grouping so the
// bit sampled on the following edge becomes lane 0 of a fresh word.
// Assumes: LANES is a power of two and at least 2.
module seg_capture_demux #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic             bit_in,
    output logic [LANES-1:0] word_q,
    output logic             word_vld
);
    localparam int PH_W = $clog2(LANES);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(LANES - 1);

    logic [PH_W-1:0]  phase;
    logic [LANES-2:0] acc;

    // Phase counter and partial-word accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || sync) begin
            phase <= '0;
            acc   <= '0;
        end else begin
            phase <= phase + 1'b1;
            if (phase != PH_LAST) acc[phase] <= bit_in;
        end
    end

    // Word output register with one-cycle valid on every LANES-th bit.
    always_ff @(posedge clk) begin
        if (!rst_n || sync) begin
            word_q   <= '0;
            word_vld <= 1'b0;
        end else if (phase == PH_LAST) begin
            word_q   <= {bit_in, acc};
            word_vld <= 1'b1;
        end else begin
            word_vld <= 1'b0;
        end
    end

    // Words are produced at most once every LANES cycles.
    AST_WORD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);  // R1

endmodule

// File: rtl/seg_capture_bank.sv
// One capture bank: LANES parallel shift registers, DEPTH stages each.
// A shift pushes a new word into stage 0. After DEPTH shifts the oldest word
// sits in stage DEPTH-1. The read port addresses words by arrival order
// (0 = oldest) and selects one lane.
// Assumes: the bank has been shifted exactly DEPTH times before reading.
module seg_capture_bank #(
    parameter int LANES = 4,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic [LANES-1:0]         word_in,
    input  logic [$clog2(DEPTH)-1:0] rd_word,
    input  logic [$clog2(LANES)-1:0] rd_lane,
    output logic                     rd_bit
);
    localparam int WORD_W = $clog2(DEPTH);
    localparam logic [WORD_W-1:0] LAST_STAGE = WORD_W'(DEPTH - 1);

    logic [LANES-1:0] stg [DEPTH];

    // Stage 0 takes the incoming word.
    always_ff @(posedge clk) begin
        if (!rst_n)        stg[0] <= '0;
        else if (shift_en) stg[0] <= word_in;
    end

    // Every later stage takes its neighbour's word.
    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)        stg[i] <= '0;
            else if (shift_en) stg[i] <= stg[i-1];
        end
    end

    // Arrival-order read: the oldest word is in the deepest stage.
    always_comb begin
        rd_bit = stg[LAST_STAGE - rd_word][rd_lane];
    end

endmodule

// File: rtl/seg_capture_ctrl.sv
// Two-window bit-stream capture controller (top).
// Groups the serial stream into words and fills bank A. It then drops
// gap_bits>>2 words, fills bank B, and shifts all stored bits out on sout,
// one per rd_step. The gap is latched when arm is accepted.
// Assumes: rd_step is a single-cycle strobe in the clk domain, and
// LANES and DEPTH are powers of two.
module seg_capture_ctrl
    import seg_capture_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 32,
    parameter int GAP_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             arm,
    input  logic [GAP_W-1:0] gap_bits,
    input  logic             rd_step,
    output logic             sout,
    output logic             busy,
    output logic             done
);
    localparam int LANE_W = $clog2(LANES);
    localparam int WORD_W = $clog2(DEPTH);
    localparam int RD_W   = LANE_W + WORD_W + 1;
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(DEPTH - 1);
    localparam logic [RD_W-1:0]   LAST_BIT  = RD_W'(2 * LANES * DEPTH - 1);

    cap_state_t       state;
    logic             accept;
    logic [LANES-1:0] word_q;
    logic             word_vld;
    logic [WORD_W-1:0] wcnt;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] skip_cnt;
    logic [GAP_W-1:0] skip_words;
    logic [RD_W-1:0]  rd_idx;
    logic             shift_a, shift_b;
    logic             bit_a, bit_b;

    // Arm is honoured only in the idle phase.
    always_comb accept = (state == ST_IDLE) && arm;

    // The gap in words: low bits of the bit count are dropped.
    always_comb skip_words = gap_q >> LANE_W;

    seg_capture_demux #(.LANES(LANES)) u_demux (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync    (accept),
        .bit_in  (bit_in),
        .word_q  (word_q),
        .word_vld(word_vld)
    );

    // Bank write enables follow the fill phase.
    always_comb begin
        shift_a = (state == ST_FILL_A) && word_vld;
        shift_b = (state == ST_FILL_B) && word_vld;
    end

    seg_capture_bank #(.LANES(LANES), .DEPTH(DEPTH)) u_bank_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_a),
        .word_in (word_q),
        .rd_word (rd_idx[LANE_W +: WORD_W]),
        .rd_lane (rd_idx[LANE_W-1:0]),
        .rd_bit  (bit_a)
    );

    seg_capture_bank #(.LANES(LANES), .DEPTH(DEPTH)) u_bank_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_b),
        .word_in (word_q),
        .rd_word (rd_idx[LANE_W +: WORD_W]),
        .rd_lane (rd_idx[LANE_W-1:0]),
        .rd_bit  (bit_b)
    );

    // Latch the gap when a capture starts.
    always_ff @(posedge clk) begin
        if (!rst_n)      gap_q <= '0;
        else if (accept) gap_q <= gap_bits;
    end

    // Phase sequencer with word, gap and readout counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wcnt     <= '0;
            skip_cnt <= '0;
            rd_idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    wcnt   <= '0;
                    rd_idx <= '0;
                    if (accept) state <= ST_FILL_A;
                end
                ST_FILL_A: if (word_vld) begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == LAST_WORD) begin
                        wcnt     <= '0;
                        skip_cnt <= skip_words;
                        state    <= (skip_words == '0) ? ST_FILL_B : ST_SKIP;
                    end
                end
                ST_SKIP: if (word_vld) begin
                    skip_cnt <= skip_cnt - 1'b1;
                    if (skip_cnt == GAP_W'(1)) state <= ST_FILL_B;
                end
                ST_FILL_B: if (word_vld) begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == LAST_WORD) begin
                        wcnt   <= '0;
                        rd_idx <= '0;
                        state  <= ST_READOUT;
                    end
                end
                ST_READOUT: if (rd_step) begin
                    rd_idx <= rd_idx + 1'b1;
                    if (rd_idx == LAST_BIT) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode: bank select by the top readout index bit.
    always_comb begin
        sout = (state == ST_READOUT) && (rd_idx[RD_W-1] ? bit_b : bit_a);
        busy = (state != ST_IDLE) && (state != ST_DONE);
        done = (state == ST_DONE);
    end

    AST_FILL_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_FILL_A) |=> (state != ST_FILL_A));  // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READOUT && !rd_step) |=> $stable(rd_idx));  // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));  // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(rd_idx) == LAST_BIT && $past(rd_step)));  // R9

    AST_SKIP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (skip_cnt != '0));  // R3

endmodule

// File: tb/sim_seg_capture_ctrl.sv
module sim_seg_capture_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        arm = 1'b0;
    logic [13:0] gap_bits = '0;
    logic        rd_step = 1'b0;
    logic        sout, busy, done;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;

    always #5 clk = ~clk;

    seg_capture_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .arm(arm),
        .gap_bits(gap_bits), .rd_step(rd_step),
        .sout(sout), .busy(busy), .done(done)
    );

    // Vector table: gap value and disturbance flags
    // flag bit0: arm pulses mid-capture (R7); bit1: rd_step during capture (R6);
    // bit2: gap_bits changed after arm (R12)
    localparam int NV = 6;
    localparam logic [13:0] V_GAP  [NV] = '{14'd0, 14'd4, 14'd6, 14'd100, 14'd8188, 14'd16383};
    localparam logic [2:0]  V_FLAG [NV] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b111, 3'b000};

    function automatic logic stream_bit(input int n, input int seed);
        logic [31:0] h;
        h = (32'(n) * 32'h9E3779B1) ^ 32'(seed);
        return h[17] ^ h[5] ^ h[29] ^ h[11];
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Arm and feed the stream; returns with the block in readout.
    task automatic capture(input logic [13:0] gap, input logic [2:0] flg, input int seed);
        int geff;
        geff = int'(gap) & ~3;
        @(negedge clk);
        gap_bits = gap;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        check("R8", busy, 1'b1, "busy after arm");
        if (flg[2]) gap_bits = ~gap;
        for (int n = 0; n < 256 + geff + 8; n++) begin
            bit_in = stream_bit(n, seed);
            arm = flg[0] && (n == 64 || n == 128 + geff / 2 || n == 200 + geff);
            rd_step = flg[1] && (n == 30 || n == 129 + geff / 2 || n == 230 + geff);
            @(negedge clk);
        end
        arm = 1'b0;
        rd_step = 1'b0;
        bit_in = 1'b0;
    endtask

    // Step through all 256 bits with stalls, then check the done pulse.
    task automatic readout(input logic [13:0] gap, input int seed, input string req);
        int geff;
        int errs;
        int hold_errs;
        logic e;
        geff = int'(gap) & ~3;
        errs = 0;
        hold_errs = 0;
        for (int k = 0; k < 256; k++) begin
            e = (k < 128) ? stream_bit(k, seed) : stream_bit(k + geff, seed);
            if (k % 5 == 2) begin
                @(negedge clk);
                if (sout !== e) hold_errs++;
            end
            if (sout !== e) begin
                if (errs == 0)
                    $display("FAIL %s readout bit %0d gap %0d: actual %0b expected %0b",
                             req, k, gap, sout, e);
                errs++;
            end
            rd_step = 1'b1;
            @(negedge clk);
            rd_step = 1'b0;
        end
        n_chk++;
        if (errs != 0) n_bad++;
        n_chk++;
        if (hold_errs != 0) begin
            n_bad++;
            $display("FAIL R6 stall hold gap %0d: actual %0d changes expected 0", gap, hold_errs);
        end
        check("R9", done, 1'b1, "done after last step");
        check("R9", busy, 1'b0, "busy low with done");
        @(negedge clk);
        check("R9", done, 1'b0, "done one cycle only");
        check("R8", busy, 1'b0, "busy low when idle");
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_bad++;
                n_chk++;
                $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", busy, 1'b0, "busy in reset");
        check("R10", done, 1'b0, "done in reset");
        check("R10", sout, 1'b0, "sout in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", busy, 1'b0, "busy idle");
        check("R6", sout, 1'b0, "sout idle");

        // Table walk: R1 R2 R3 R4 R5 R7 R11 R12 via readout comparison
        for (int v = 0; v < NV; v++) begin
            capture(V_GAP[v], V_FLAG[v], 101 + v * 7);
            check("R8", busy, 1'b1, "busy in readout");
            readout(V_GAP[v], 101 + v * 7,
                    (V_GAP[v] == 0) ? "R4" : ((V_GAP[v][1:0] != 0) ? "R11" : "R3"));
        end

        // R10: reset during capture abandons it, then a fresh capture works
        @(negedge clk);
        gap_bits = 14'd12;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        repeat (40) begin bit_in = ~bit_in; @(negedge clk); end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10", busy, 1'b0, "busy after mid-capture reset");
        @(negedge clk);
        check("R10", busy, 1'b0, "still idle after reset");
        capture(14'd12, 3'b000, 999);
        readout(14'd12, 999, "R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule